// File: doc/BRIEF.md
# PTP Frame Timestamp Capture Unit

This block watches the transmit and receive paths of an Ethernet MAC and, at the start of each frame, latches the live time-of-day counter. The counter is given as seconds and nanoseconds. For frames that are PTP event messages, the captured time goes into one of four capture register pairs. The pair is chosen by direction and by whether the message is a peer event. Peer event messages are the ones whose message-type byte has bit 1 set.

Alongside the register capture, each direction produces a compact two-word descriptor timestamp for the DMA engine. That timestamp holds the full nanoseconds value and only the six lowest seconds bits. Software rebuilds the upper seconds from the capture registers. A 2-bit mode input per direction selects when a descriptor timestamp is produced. The receive side also gives a flag that the status word of the current receive descriptor carries in bit 2.

Top module: `ptp_stamp_capture`

## Requirements
- R1: After reset, every capture register, both descriptor word pairs, both descriptor write strobes and the receive valid flag are zero.
- R2: A transmit frame start with the PTP flag high and message-type bit 1 clear loads the transmit event pair with the seconds and nanoseconds present in that cycle. Both values come from the same cycle. The transmit peer pair does not change.
- R3: A frame start with the PTP flag high and message-type bit 1 set loads the peer pair of that direction. The event pair of that direction does not change.
- R4: The receive direction captures into its own event and peer pairs. A receive frame never changes the transmit pairs, and a transmit frame never changes the receive pairs.
- R5: A frame start with the PTP flag low leaves all four capture pairs unchanged.
- R6: Descriptor low word: bits [29:0] hold the captured nanoseconds and bits [31:30] hold seconds bits [1:0].
- R7: Descriptor high word: bits [3:0] hold seconds bits [5:2], and bits [31:4] are zero.
- R8: In mode 01, a descriptor timestamp is produced only for PTP frames. Producing one means that the write strobe is high for the single cycle after the frame start and that the words are updated.
- R9: In mode 10, a descriptor timestamp is produced for every frame.
- R10: In mode 00 or 11, no descriptor timestamp is produced. The descriptor words keep their earlier values and the strobe stays low.
- R11: The receive valid flag shows whether the most recent receive frame produced a descriptor timestamp. It holds that value until the next receive frame start.
- R12: A later capture into the same pair overwrites the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_sec | input | SEC_W | Live seconds count |
| now_ns | input | 30 | Live nanoseconds count |
| tx_sof | input | 1 | Transmit frame-start strobe |
| tx_is_ptp | input | 1 | Transmit frame is a PTP event message |
| tx_msg_type | input | 8 | Transmit PTP message-type byte |
| tx_mode | input | 2 | Transmit descriptor timestamp mode |
| rx_sof | input | 1 | Receive frame-start strobe |
| rx_is_ptp | input | 1 | Receive frame is a PTP event message |
| rx_msg_type | input | 8 | Receive PTP message-type byte |
| rx_mode | input | 2 | Receive descriptor timestamp mode |
| tx_evt_sec | output | SEC_W | Transmit event capture, seconds |
| tx_evt_ns | output | 30 | Transmit event capture, nanoseconds |
| tx_peer_sec | output | SEC_W | Transmit peer capture, seconds |
| tx_peer_ns | output | 30 | Transmit peer capture, nanoseconds |
| rx_evt_sec | output | SEC_W | Receive event capture, seconds |
| rx_evt_ns | output | 30 | Receive event capture, nanoseconds |
| rx_peer_sec | output | SEC_W | Receive peer capture, seconds |
| rx_peer_ns | output | 30 | Receive peer capture, nanoseconds |
| tx_desc_lo | output | 32 | Transmit descriptor timestamp, low word |
| tx_desc_hi | output | 32 | Transmit descriptor timestamp, high word |
| tx_desc_wr | output | 1 | Transmit descriptor timestamp write strobe |
| rx_desc_lo | output | 32 | Receive descriptor timestamp, low word |
| rx_desc_hi | output | 32 | Receive descriptor timestamp, high word |
| rx_desc_wr | output | 1 | Receive descriptor timestamp write strobe |
| rx_ts_valid | output | 1 | Receive descriptor holds a valid timestamp |

## Verification
The assertions assume a frame-start strobe lasts one cycle. They also assume the PTP flag and message-type byte are valid in that same cycle, and that the nanoseconds input stays below 2^30. The bench holds each strobe for exactly one cycle and drives all side inputs together with it. It gives the time inputs a distinct value for each frame, so that a pair capturing at the wrong moment or into the wrong slot shows up as a mismatch.

// File: rtl/ptp_stamp_capture.sv
module ptp_stamp_capture #(
  parameter int SEC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] now_sec,
  input  logic [29:0]      now_ns,
  input  logic             tx_sof,
  input  logic             tx_is_ptp,
  input  logic [7:0]       tx_msg_type,
  input  logic [1:0]       tx_mode,
  input  logic             rx_sof,
  input  logic             rx_is_ptp,
  input  logic [7:0]       rx_msg_type,
  input  logic [1:0]       rx_mode,
  output logic [SEC_W-1:0] tx_evt_sec,
  output logic [29:0]      tx_evt_ns,
  output logic [SEC_W-1:0] tx_peer_sec,
  output logic [29:0]      tx_peer_ns,
  output logic [SEC_W-1:0] rx_evt_sec,
  output logic [29:0]      rx_evt_ns,
  output logic [SEC_W-1:0] rx_peer_sec,
  output logic [29:0]      rx_peer_ns,
  output logic [31:0]      tx_desc_lo,
  output logic [31:0]      tx_desc_hi,
  output logic             tx_desc_wr,
  output logic [31:0]      rx_desc_lo,
  output logic [31:0]      rx_desc_hi,
  output logic             rx_desc_wr,
  output logic             rx_ts_valid
);
  localparam int NS_W  = 30;
  localparam int HI_PAD = 32 - 4;

  logic [1:0]      sof, ptp, peer, stamp;
  logic [1:0][1:0] mode;
  logic [13:0]     unused_msg;

  assign sof  = {rx_sof, tx_sof};
  assign ptp  = {rx_is_ptp, tx_is_ptp};
  assign peer = {rx_msg_type[1], tx_msg_type[1]};
  assign mode = {rx_mode, tx_mode};
  assign unused_msg = {rx_msg_type[7:2], rx_msg_type[0], tx_msg_type[7:2], tx_msg_type[0]};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [1:0][SEC_W-1:0] cs;
    logic [1:0][NS_W-1:0]  cn;
    logic [31:0]           lo, hi;
    logic                  wr;

    assign stamp[d] = (mode[d] == 2'b10) || (mode[d] == 2'b01 && ptp[d]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cs <= '0;
        cn <= '0;
        lo <= '0;
        hi <= '0;
        wr <= 1'b0;
      end else begin
        wr <= sof[d] && stamp[d];
        if (sof[d] && ptp[d]) begin
          cs[peer[d]] <= now_sec;
          cn[peer[d]] <= now_ns;
        end
        if (sof[d] && stamp[d]) begin
          lo <= {now_sec[1:0], now_ns};
          hi <= {{HI_PAD{1'b0}}, now_sec[5:2]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rx_ts_valid <= 1'b0;
    else if (rx_sof) rx_ts_valid <= stamp[1];
  end

  assign tx_evt_sec  = g_dir[0].cs[0];
  assign tx_evt_ns   = g_dir[0].cn[0];
  assign tx_peer_sec = g_dir[0].cs[1];
  assign tx_peer_ns  = g_dir[0].cn[1];
  assign rx_evt_sec  = g_dir[1].cs[0];
  assign rx_evt_ns   = g_dir[1].cn[0];
  assign rx_peer_sec = g_dir[1].cs[1];
  assign rx_peer_ns  = g_dir[1].cn[1];
  assign tx_desc_lo  = g_dir[0].lo;
  assign tx_desc_hi  = g_dir[0].hi;
  assign tx_desc_wr  = g_dir[0].wr;
  assign rx_desc_lo  = g_dir[1].lo;
  assign rx_desc_hi  = g_dir[1].hi;
  assign rx_desc_wr  = g_dir[1].wr;
endmodule

// File: rtl/ptp_stamp_capture_chk.sv
module ptp_stamp_capture_chk #(
  parameter int SEC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEC_W-1:0] now_sec,
  input logic [29:0]      now_ns,
  input logic             tx_sof,
  input logic             tx_is_ptp,
  input logic [7:0]       tx_msg_type,
  input logic             rx_sof,
  input logic             rx_is_ptp,
  input logic [7:0]       rx_msg_type,
  input logic [1:0]       rx_mode,
  input logic [SEC_W-1:0] tx_evt_sec,
  input logic [29:0]      tx_evt_ns,
  input logic [SEC_W-1:0] tx_peer_sec,
  input logic [SEC_W-1:0] rx_evt_sec,
  input logic [SEC_W-1:0] rx_peer_sec,
  input logic [31:0]      tx_desc_lo,
  input logic [31:0]      tx_desc_hi,
  input logic             tx_desc_wr,
  input logic             rx_desc_wr,
  input logic             rx_ts_valid
);
  p_evt_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof && tx_is_ptp && !tx_msg_type[1]) |=>
      (tx_evt_sec == $past(now_sec) && tx_evt_ns == $past(now_ns)));

  p_peer_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof && tx_is_ptp && !tx_msg_type[1]) |=> $stable(tx_peer_sec));

  p_evt_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof && rx_is_ptp && rx_msg_type[1]) |=> $stable(rx_evt_sec));

  p_non_ptp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof && !tx_is_ptp && !rx_sof) |=>
      ($stable(tx_evt_sec) && $stable(tx_peer_sec) && $stable(rx_evt_sec) && $stable(rx_peer_sec)));

  p_lo_format_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_desc_wr |-> (tx_desc_lo == {$past(now_sec[1:0]), $past(now_ns)}));

  p_hi_format_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_desc_wr |-> (tx_desc_hi == {28'd0, $past(now_sec[5:2])}));

  p_wr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_sof |=> !tx_desc_wr);

  p_off_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof && (rx_mode == 2'b00 || rx_mode == 2'b11)) |=> (!rx_desc_wr && !rx_ts_valid));

  p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_desc_wr |-> rx_ts_valid);

  p_valid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_sof |=> $stable(rx_ts_valid));
endmodule

bind ptp_stamp_capture ptp_stamp_capture_chk #(.SEC_W(SEC_W)) u_chk (.*);

// File: tb/ptp_stamp_capture_tb.sv
`timescale 1ns/1ps
module ptp_stamp_capture_tb;
  localparam int SW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] now_sec = '0;
  logic [29:0]   now_ns = '0;
  logic          tx_sof = 0, tx_is_ptp = 0, rx_sof = 0, rx_is_ptp = 0;
  logic [7:0]    tx_msg_type = '0, rx_msg_type = '0;
  logic [1:0]    tx_mode = '0, rx_mode = '0;
  logic [SW-1:0] tx_evt_sec, tx_peer_sec, rx_evt_sec, rx_peer_sec;
  logic [29:0]   tx_evt_ns, tx_peer_ns, rx_evt_ns, rx_peer_ns;
  logic [31:0]   tx_desc_lo, tx_desc_hi, rx_desc_lo, rx_desc_hi;
  logic          tx_desc_wr, rx_desc_wr, rx_ts_valid;

  always #2.5 clk = ~clk;

  ptp_stamp_capture #(.SEC_W(SW)) u_dut (.*);

  int total = 0, bad = 0;
  logic [SW-1:0] e_sec [4];
  logic [29:0]   e_ns  [4];
  logic [31:0]   e_lo  [2];
  logic [31:0]   e_hi  [2];
  logic          e_val = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_caps(input string tag);
    chk({tag, " tx evt sec"},  64'(tx_evt_sec),  64'(e_sec[0]));
    chk({tag, " tx evt ns"},   64'(tx_evt_ns),   64'(e_ns[0]));
    chk({tag, " tx peer sec"}, 64'(tx_peer_sec), 64'(e_sec[1]));
    chk({tag, " tx peer ns"},  64'(tx_peer_ns),  64'(e_ns[1]));
    chk({tag, " rx evt sec"},  64'(rx_evt_sec),  64'(e_sec[2]));
    chk({tag, " rx evt ns"},   64'(rx_evt_ns),   64'(e_ns[2]));
    chk({tag, " rx peer sec"}, 64'(rx_peer_sec), 64'(e_sec[3]));
    chk({tag, " rx peer ns"},  64'(rx_peer_ns),  64'(e_ns[3]));
  endtask

  // one frame start in one direction; checks every output one cycle later
  task automatic frame(input string tag, input bit rx, input bit ptp, input logic [7:0] mt,
                       input logic [1:0] md, input logic [SW-1:0] s, input logic [29:0] n);
    bit go;
    int idx;
    go  = (md == 2'b10) || (md == 2'b01 && ptp);
    idx = (rx ? 2 : 0) + (mt[1] ? 1 : 0);
    @(negedge clk);
    now_sec = s;
    now_ns  = n;
    if (rx) begin rx_sof = 1; rx_is_ptp = ptp; rx_msg_type = mt; rx_mode = md; end
    else    begin tx_sof = 1; tx_is_ptp = ptp; tx_msg_type = mt; tx_mode = md; end
    @(negedge clk);
    tx_sof = 0;
    rx_sof = 0;
    now_sec = ~s;
    now_ns  = ~n;
    if (ptp) begin e_sec[idx] = s; e_ns[idx] = n; end
    if (go) begin
      e_lo[rx] = {s[1:0], n};
      e_hi[rx] = {28'd0, s[5:2]};
    end
    if (rx) e_val = go;
    chk_caps(tag);
    chk({tag, " tx lo"}, 64'(tx_desc_lo), 64'(e_lo[0]));
    chk({tag, " tx hi"}, 64'(tx_desc_hi), 64'(e_hi[0]));
    chk({tag, " rx lo"}, 64'(rx_desc_lo), 64'(e_lo[1]));
    chk({tag, " rx hi"}, 64'(rx_desc_hi), 64'(e_hi[1]));
    chk({tag, " tx wr"}, 64'(tx_desc_wr), 64'(go && !rx));
    chk({tag, " rx wr"}, 64'(rx_desc_wr), 64'(go && rx));
    chk({tag, " rx valid"}, 64'(rx_ts_valid), 64'(e_val));
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin e_sec[i] = '0; e_ns[i] = '0; end
    for (int i = 0; i < 2; i++) begin e_lo[i] = '0; e_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_caps("R1 reset");
    chk("R1 reset tx lo", 64'(tx_desc_lo), 64'd0);
    chk("R1 reset rx hi", 64'(rx_desc_hi), 64'd0);
    chk("R1 reset wr", 64'({tx_desc_wr, rx_desc_wr}), 64'd0);
    chk("R1 reset valid", 64'(rx_ts_valid), 64'd0);
  endtask

  task automatic t_tx_event;
    frame("R2 tx event", 0, 1, 8'h00, 2'b01, 48'h1234_5678_9ABD, 30'h2ABC_DEF1);
    frame("R2 tx event b", 0, 1, 8'hFD, 2'b01, 48'h0000_0000_003F, 30'h3FFF_FFFF);
  endtask

  task automatic t_tx_peer;
    frame("R3 tx peer", 0, 1, 8'h02, 2'b01, 48'hA5A5_0000_1117, 30'h0123_4567);
  endtask

  task automatic t_rx_dirs;
    frame("R4 rx event", 1, 1, 8'h01, 2'b01, 48'h0F0F_F0F0_0022, 30'h1000_0001);
    frame("R4 rx peer",  1, 1, 8'h03, 2'b01, 48'h7777_8888_99AA, 30'h0555_5555);
  endtask

  task automatic t_non_ptp;
    frame("R5 tx non-ptp", 0, 0, 8'h00, 2'b01, 48'hDEAD_BEEF_0001, 30'h0000_0042);
    frame("R5 rx non-ptp", 1, 0, 8'h02, 2'b00, 48'hDEAD_BEEF_0002, 30'h0000_0043);
  endtask

  task automatic t_format;
    frame("R6 R7 format", 0, 1, 8'h00, 2'b10, 48'hFFFF_FFFF_FFE9, 30'h1555_AAAA);
    chk("R6 lo top bits", 64'(tx_desc_lo[31:30]), 64'd1);
    chk("R7 hi field", 64'(tx_desc_hi), 64'h0000_000A);
  endtask

  task automatic t_modes;
    frame("R8 mode01 non-ptp", 1, 0, 8'h00, 2'b01, 48'h0000_1111_0005, 30'h0000_0100);
    frame("R9 mode10 non-ptp", 1, 0, 8'h00, 2'b10, 48'h0000_2222_0036, 30'h0000_0200);
    frame("R9 mode10 tx non-ptp", 0, 0, 8'h00, 2'b10, 48'h0000_2222_0011, 30'h0000_0201);
    frame("R10 mode00 ptp", 1, 1, 8'h00, 2'b00, 48'h0000_3333_0007, 30'h0000_0300);
    frame("R9 mode10 ptp", 1, 1, 8'h02, 2'b10, 48'h0000_4444_002C, 30'h0000_0400);
    frame("R10 mode11 ptp", 1, 1, 8'h00, 2'b11, 48'h0000_5555_0019, 30'h0000_0500);
    frame("R10 tx mode11", 0, 1, 8'h00, 2'b11, 48'h0000_5555_001A, 30'h0000_0501);
  endtask

  task automatic t_valid_hold;
    frame("R11 set", 1, 1, 8'h00, 2'b01, 48'h0000_0000_0004, 30'h0000_0600);
    repeat (3) @(negedge clk);
    chk("R11 valid held", 64'(rx_ts_valid), 64'd1);
    chk("R8 strobe single cycle", 64'(rx_desc_wr), 64'd0);
    frame("R11 tx leaves valid", 0, 1, 8'h00, 2'b00, 48'h0000_0000_0008, 30'h0000_0700);
    chk("R11 valid after tx", 64'(rx_ts_valid), 64'd1);
  endtask

  task automatic t_overwrite;
    frame("R12 first",  0, 1, 8'h02, 2'b00, 48'h0000_0000_1000, 30'h0000_1000);
    frame("R12 second", 0, 1, 8'h02, 2'b00, 48'h0000_0000_2000, 30'h0000_2000);
    chk("R12 peer newest", 64'(tx_peer_ns), 64'h2000);
  endtask

  bit done = 0;
  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tx_event();
    t_tx_peer();
    t_rx_dirs();
    t_non_ptp();
    t_format();
    t_modes();
    t_valid_hold();
    t_overwrite();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule